// File: doc/BRIEF.md
# Active-Video Line Delay Buffer

This block sits between a video decoder front end and a display pipeline. Both run on one free-running sample clock. Every clock carries one 4:2:2 sample: an 8-bit luma code and an 8-bit multiplexed chroma code. A front-end line sync marks sample position 0 of each incoming line. Counting from that position, a programmable start offset opens a write window of exactly `LINE_LEN` samples, and only the samples inside that window enter the buffer.

A separate display line sync starts the read-out of one line. Because the read sync is independent of the write sync, the delay between input and output can be fixed (for example, one whole line) or can drift, which suits timebase correction. The buffer holds two lines.

If a read starts before a full line is stored, a blanking line is sent instead and a sticky flag is raised. A write that finds the buffer full is dropped and raises a second sticky flag. The chroma output can be switched from offset binary to two's complement.

Top module: `lvd_line_delay`

## Requirements
- R1: The front-end sync cycle is sample position 0. Only the samples at positions `win_ofs` to `win_ofs+LINE_LEN-1` are stored, which is exactly `LINE_LEN` per line, and no other sample is stored.
- R2: Stored samples come out in the order they were written. Luma and offset-binary chroma come out unchanged.
- R3: If `disp_hsync` is high in a clock cycle while no line is being read, a read begins. `out_valid` rises at the second rising edge after that cycle and stays high for exactly `LINE_LEN` consecutive cycles.
- R4: A `disp_hsync` pulse that arrives while a line is being read is ignored. It neither restarts nor extends that read.
- R5: A read may start while fewer than `LINE_LEN` samples are stored. In that case every sample of the line is blanking (luma 16, chroma 128 in offset binary), no stored sample is consumed, and `underflow` is set.
- R6: When `chroma_twos` is 1, `out_c` has its MSB inverted relative to offset binary (128 becomes 0, 0x6E becomes 0xEE). This also applies to blanking chroma. Luma is never affected.
- R7: The buffer holds `2*LINE_LEN` samples. A write that finds it full is dropped and sets `overflow`. The samples already stored are read out intact.
- R8: After reset, `out_valid`, `underflow` and `overflow` are 0. Once set, `underflow` and `overflow` stay set until reset.
- R9: While `out_valid` is 0, `out_y` is 16 and `out_c` is the blanking chroma (128, or 0 when `chroma_twos` is 1).
- R10: One line can be read while the next line is being written. This gives a delay of one full line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_hsync | input | 1 | Front-end line sync pulse (position 0) |
| win_ofs | input | OFS_W | Write window start, in samples after position 0 |
| in_y | input | 8 | Input luma code |
| in_c | input | 8 | Input chroma code, offset binary |
| disp_hsync | input | 1 | Display line sync pulse; starts a line read |
| chroma_twos | input | 1 | 1 selects two's-complement chroma output |
| out_y | output | 8 | Delayed luma |
| out_c | output | 8 | Delayed chroma in the selected format |
| out_valid | output | 1 | High while a line's samples are on the output |
| underflow | output | 1 | Sticky: a read started without a full line stored |
| overflow | output | 1 | Sticky: a write was dropped because the buffer was full |

## Verification
A wrong fill count or pointer shows up at the ports within one line. Either a blanking line appears where data was stored, or the luma values come out shifted or repeated relative to the input ramp. A window counter that is off by one moves every luma value by one code, which is visible in the first output sample of the next read. A read sequencer that miscounts shows up in the same line's `out_valid` run, which is either longer or shorter than `LINE_LEN`, or in a second run started by an ignored sync. Lost sticky state shows up as a flag that drops on the next cycle.

// File: rtl/lvd_pkg.sv
`timescale 1ns/1ps
package lvd_pkg;
  localparam int SW = 8;
  localparam logic [SW-1:0] BLANK_Y = 8'd16;
  localparam logic [SW-1:0] BLANK_C = 8'd128;

  typedef struct packed {
    logic [SW-1:0] y;
    logic [SW-1:0] c;
  } lvd_sample_t;

  // position pos (0 = sync cycle) falls inside a window of len samples at ofs
  function automatic logic win_hit(input int pos, input int ofs, input int len);
    return (pos >= ofs) && (pos < ofs + len);
  endfunction

  // offset binary to output format: two's complement flips the MSB
  function automatic logic [SW-1:0] fmt_chroma(input logic [SW-1:0] c, input logic twos);
    return c ^ {twos, {(SW-1){1'b0}}};
  endfunction
endpackage

// File: rtl/lvd_window.sv
`timescale 1ns/1ps
module lvd_window #(
  parameter int LINE_LEN = 1068,
  parameter int OFS_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fe_hsync,
  input  logic [OFS_W-1:0] win_ofs,
  output logic             wr_req
);
  import lvd_pkg::*;
  localparam int POS_W = $clog2((2 ** OFS_W) + LINE_LEN + 1);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos;

  // the sync cycle itself is position 0
  assign pos    = fe_hsync ? '0 : pos_q;
  assign wr_req = win_hit(32'(pos), 32'(win_ofs), LINE_LEN);

  always_ff @(posedge clk) begin
    if (!rst_n)           pos_q <= '1;
    else if (fe_hsync)    pos_q <= POS_W'(1);
    else if (pos_q != '1) pos_q <= pos_q + POS_W'(1);
  end
endmodule

// File: rtl/lvd_store.sv
`timescale 1ns/1ps
module lvd_store #(
  parameter int LINE_LEN = 1068,
  parameter int DEPTH    = 2136
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_req,
  input  lvd_pkg::lvd_sample_t         wr_word,
  input  logic                         pop,
  output lvd_pkg::lvd_sample_t         rd_word,
  output logic                         line_ready,
  output logic                         wr_drop,
  output logic [$clog2(DEPTH+1)-1:0]   fill,
  output logic                         overflow
);
  import lvd_pkg::*;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int FILL_W = $clog2(DEPTH + 1);

  lvd_sample_t       mem [DEPTH];
  logic [ADDR_W-1:0] wptr, rptr;
  logic [FILL_W-1:0] fill_q;
  logic              full, wr_do, ovf_q;

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] p);
    return (p == ADDR_W'(DEPTH - 1)) ? '0 : p + ADDR_W'(1);
  endfunction

  assign full       = (fill_q == FILL_W'(DEPTH));
  assign wr_do      = wr_req && !full;
  assign wr_drop    = wr_req && full;
  assign line_ready = (fill_q >= FILL_W'(LINE_LEN));
  assign fill       = fill_q;
  assign overflow   = ovf_q;

  always_ff @(posedge clk) begin
    if (wr_do) mem[wptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      fill_q  <= '0;
      ovf_q   <= 1'b0;
      rd_word <= '0;
    end else begin
      if (wr_do) wptr <= step(wptr);
      if (pop) begin
        rd_word <= mem[rptr];
        rptr    <= step(rptr);
      end
      fill_q <= fill_q + FILL_W'(wr_do) - FILL_W'(pop);
      if (wr_drop) ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lvd_reader.sv
`timescale 1ns/1ps
module lvd_reader #(
  parameter int LINE_LEN = 1068
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 disp_hsync,
  input  logic                 line_ready,
  input  lvd_pkg::lvd_sample_t rd_word,
  input  logic                 chroma_twos,
  output logic                 pop,
  output logic                 rd_start,
  output logic                 rd_start_blank,
  output logic [7:0]           out_y,
  output logic [7:0]           out_c,
  output logic                 out_valid,
  output logic                 underflow
);
  import lvd_pkg::*;
  localparam int CNT_W = $clog2(LINE_LEN + 1);

  logic [CNT_W-1:0] rd_left;
  logic             rd_active, blank_line;
  logic             vld_q, oblank_q, unf_q;
  logic             show_data;

  assign rd_active      = (rd_left != '0);
  assign rd_start       = disp_hsync && !rd_active;
  assign rd_start_blank = rd_start && !line_ready;
  assign pop            = rd_active && !blank_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_left    <= '0;
      blank_line <= 1'b0;
      vld_q      <= 1'b0;
      oblank_q   <= 1'b0;
      unf_q      <= 1'b0;
    end else begin
      if (rd_start) begin
        rd_left    <= CNT_W'(LINE_LEN);
        blank_line <= !line_ready;
      end else if (rd_active) begin
        rd_left <= rd_left - CNT_W'(1);
      end
      vld_q    <= rd_active;
      oblank_q <= blank_line;
      if (rd_start_blank) unf_q <= 1'b1;
    end
  end

  assign show_data = vld_q && !oblank_q;
  assign out_valid = vld_q;
  assign underflow = unf_q;
  assign out_y     = show_data ? rd_word.y : BLANK_Y;
  assign out_c     = fmt_chroma(show_data ? rd_word.c : BLANK_C, chroma_twos);
endmodule

// File: rtl/lvd_line_delay.sv
`timescale 1ns/1ps
module lvd_line_delay #(
  parameter int LINE_LEN    = 1068,
  parameter int DEPTH_LINES = 2,
  parameter int OFS_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fe_hsync,
  input  logic [OFS_W-1:0] win_ofs,
  input  logic [7:0]       in_y,
  input  logic [7:0]       in_c,
  input  logic             disp_hsync,
  input  logic             chroma_twos,
  output logic [7:0]       out_y,
  output logic [7:0]       out_c,
  output logic             out_valid,
  output logic             underflow,
  output logic             overflow
);
  import lvd_pkg::*;
  localparam int DEPTH  = LINE_LEN * DEPTH_LINES;
  localparam int FILL_W = $clog2(DEPTH + 1);

  // internal events, named for the checker
  logic              wr_req, wr_drop, pop, line_ready;
  logic              rd_start, rd_start_blank;
  logic [FILL_W-1:0] fill;
  lvd_sample_t       wr_word, rd_word;

  assign wr_word = '{y: in_y, c: in_c};

  lvd_window #(.LINE_LEN(LINE_LEN), .OFS_W(OFS_W)) u_win (
    .clk(clk), .rst_n(rst_n), .fe_hsync(fe_hsync), .win_ofs(win_ofs), .wr_req(wr_req)
  );

  lvd_store #(.LINE_LEN(LINE_LEN), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_word(wr_word), .pop(pop),
    .rd_word(rd_word), .line_ready(line_ready), .wr_drop(wr_drop), .fill(fill),
    .overflow(overflow)
  );

  lvd_reader #(.LINE_LEN(LINE_LEN)) u_rd (
    .clk(clk), .rst_n(rst_n), .disp_hsync(disp_hsync), .line_ready(line_ready),
    .rd_word(rd_word), .chroma_twos(chroma_twos), .pop(pop), .rd_start(rd_start),
    .rd_start_blank(rd_start_blank), .out_y(out_y), .out_c(out_c),
    .out_valid(out_valid), .underflow(underflow)
  );
endmodule

// File: rtl/lvd_line_delay_chk.sv
`timescale 1ns/1ps
module lvd_line_delay_chk #(
  parameter int LINE_LEN = 1068,
  parameter int DEPTH    = 2136
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       disp_hsync,
  input logic                       out_valid,
  input logic [7:0]                 out_y,
  input logic [7:0]                 out_c,
  input logic                       chroma_twos,
  input logic                       underflow,
  input logic                       overflow,
  input logic                       wr_drop,
  input logic                       rd_start,
  input logic                       rd_start_blank,
  input logic                       pop,
  input logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int RUN_W = $clog2(LINE_LEN + 2);
  logic [RUN_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         run_cnt <= '0;
    else if (out_valid) run_cnt <= run_cnt + RUN_W'(1);
    else                run_cnt <= '0;
  end

  p_run_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> (run_cnt == RUN_W'(LINE_LEN)));
  p_run_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RUN_W'(LINE_LEN));
  p_ignore_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_hsync && out_valid && (run_cnt < RUN_W'(LINE_LEN - 1))) |-> !rd_start);
  p_underflow_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start_blank |=> underflow);
  p_underflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  p_overflow_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> overflow);
  p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  p_fill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= ($clog2(DEPTH+1))'(DEPTH));
  p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (fill != '0));
  p_idle_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ((out_y == 8'd16) && (out_c == (chroma_twos ? 8'd0 : 8'd128))));
endmodule

bind lvd_line_delay lvd_line_delay_chk #(.LINE_LEN(LINE_LEN), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_hsync(disp_hsync), .out_valid(out_valid),
  .out_y(out_y), .out_c(out_c), .chroma_twos(chroma_twos), .underflow(underflow),
  .overflow(overflow), .wr_drop(wr_drop), .rd_start(rd_start),
  .rd_start_blank(rd_start_blank), .pop(pop), .fill(fill)
);

// File: tb/lvd_line_delay_tb.sv
`timescale 1ns/1ps
module lvd_line_delay_tb;
  localparam int L     = 8;
  localparam int OFS_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             fe_hsync = 1'b0;
  logic [OFS_W-1:0] win_ofs = '0;
  logic [7:0]       in_y = '0, in_c = '0;
  logic             disp_hsync = 1'b0;
  logic             chroma_twos = 1'b0;
  logic [7:0]       out_y, out_c;
  logic             out_valid, underflow, overflow;

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  int first_cyc = -1;
  int cap_y[$], cap_c[$];
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  lvd_line_delay #(.LINE_LEN(L), .DEPTH_LINES(2), .OFS_W(OFS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .fe_hsync(fe_hsync), .win_ofs(win_ofs),
    .in_y(in_y), .in_c(in_c), .disp_hsync(disp_hsync), .chroma_twos(chroma_twos),
    .out_y(out_y), .out_c(out_c), .out_valid(out_valid),
    .underflow(underflow), .overflow(overflow)
  );

  always @(negedge clk) begin
    if (out_valid) begin
      cap_y.push_back(int'(out_y));
      cap_c.push_back(int'(out_c));
      if (cap_y.size() == 1) first_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive one front-end line: position p carries y=base+p, c=base+100+p
  task automatic write_line(input int base, input int ofs);
    @(posedge clk); #2;
    win_ofs  = OFS_W'(ofs);
    fe_hsync = 1'b1;
    for (int p = 0; p < ofs + L + 2; p++) begin
      in_y = 8'(base + p);
      in_c = 8'(base + 100 + p);
      if (p > 0) fe_hsync = 1'b0;
      @(posedge clk); #2;
    end
    fe_hsync = 1'b0;
  endtask

  // start one read and check the line; exp_base<0 means a blanking line
  task automatic read_line(input string req, input int exp_base, input bit extra_sync);
    int hs_cyc;
    cap_y.delete(); cap_c.delete(); first_cyc = -1;
    @(posedge clk); #2;
    disp_hsync = 1'b1; hs_cyc = cyc;
    @(posedge clk); #2;
    disp_hsync = 1'b0;
    if (extra_sync) begin
      repeat (2) @(posedge clk);
      #2 disp_hsync = 1'b1;
      @(posedge clk); #2 disp_hsync = 1'b0;
    end
    repeat (L + 4) @(posedge clk);
    #3;
    chk(cap_y.size() == L, req, "valid sample count", cap_y.size(), L);
    chk(first_cyc - hs_cyc == 2, "R3", "first valid latency", first_cyc - hs_cyc, 2);
    for (int k = 0; k < L && k < cap_y.size(); k++) begin
      int ey, ec;
      ey = (exp_base < 0) ? 16  : ((exp_base + k) & 255);
      ec = (exp_base < 0) ? 128 : ((exp_base + 100 + k) & 255);
      if (chroma_twos) ec = ec ^ 128;
      chk(cap_y[k] == ey, req, $sformatf("luma[%0d]", k), cap_y[k], ey);
      chk(cap_c[k] == ec, req, $sformatf("chroma[%0d]", k), cap_c[k], ec);
    end
    chk(out_y == 8'd16, "R9", "idle luma", int'(out_y), 16);
    chk(int'(out_c) == (chroma_twos ? 0 : 128), "R9", "idle chroma", int'(out_c),
        chroma_twos ? 0 : 128);
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R8", "reset out_valid", int'(out_valid), 0);
    chk(underflow == 1'b0, "R8", "reset underflow", int'(underflow), 0);
    chk(overflow == 1'b0, "R8", "reset overflow", int'(overflow), 0);
    chk(out_y == 8'd16, "R9", "reset luma", int'(out_y), 16);
    chk(out_c == 8'd128, "R9", "reset chroma", int'(out_c), 128);
  endtask

  task automatic t_underflow();
    read_line("R5", -1, 1'b0);
    chk(underflow == 1'b1, "R5", "underflow after empty read", int'(underflow), 1);
    chk(overflow == 1'b0, "R7", "overflow stays clear", int'(overflow), 0);
  endtask

  task automatic t_basic();
    write_line(10, 0);
    read_line("R2", 10, 1'b0);
  endtask

  task automatic t_offset();
    write_line(40, 3);
    read_line("R1", 43, 1'b0);
    read_line("R1", -1, 1'b0);  // exactly one line was stored
  endtask

  task automatic t_twos();
    chroma_twos = 1'b1;
    #1 chk(out_c == 8'd0, "R6", "idle chroma in twos", int'(out_c), 0);
    write_line(20, 0);
    read_line("R6", 20, 1'b0);
    read_line("R6", -1, 1'b0);
    chroma_twos = 1'b0;
  endtask

  task automatic t_ignore();
    write_line(60, 0);
    write_line(90, 0);
    read_line("R4", 60, 1'b1);
    read_line("R4", 90, 1'b0);
  endtask

  task automatic t_overflow();
    chk(overflow == 1'b0, "R7", "overflow before fill", int'(overflow), 0);
    write_line(120, 0);
    write_line(150, 0);
    write_line(180, 0);
    chk(overflow == 1'b1, "R7", "overflow after third line", int'(overflow), 1);
    read_line("R7", 120, 1'b0);
    read_line("R7", 150, 1'b0);
    chk(overflow == 1'b1, "R8", "overflow sticky", int'(overflow), 1);
    chk(underflow == 1'b1, "R8", "underflow sticky", int'(underflow), 1);
  endtask

  task automatic t_line_delay();
    write_line(200, 0);
    fork
      write_line(30, 0);
      read_line("R10", 200, 1'b0);
    join
    read_line("R10", 30, 1'b0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #3;
    t_reset();
    t_underflow();
    t_basic();
    t_offset();
    t_twos();
    t_ignore();
    t_overflow();
    t_line_delay();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule